// File: doc/BRIEF.md
# Integer ALU with Function Code

This block is the combinational arithmetic and logic unit of a small register-based processor core. It takes two operands and a 4-bit function code and produces one result word. Its operations are add, subtract, unsigned and signed less-than, the four bitwise operations and/nor/or/xor, three shifts, and sign extension from a byte or a halfword. There is no flags register. A compare writes 0 or 1 into the result. A separate equality output serves the branch-if-equal and branch-if-not-equal decisions.

The datapath width is a parameter, and is meant to be 16 or 32 bits. An immediate-mode input marks an instruction whose second operand is an immediate. In that mode only the compare, bitwise and shift functions are legal. Any illegal combination of function code and mode drives the result to zero and raises an invalid-function output, so the core can trap.

Top module: `int_alu`

## Requirements
- R1: Function 0 gives opA + opB and function 1 gives opA - opB. Both wrap modulo 2^WIDTH.
- R2: Function 2 gives 1 when opA < opB as unsigned numbers, and 0 otherwise. Function 3 does the same with both operands read as two's complement.
- R3: Functions 4, 5, 6 and 7 give the bitwise and, or, xor and nor of opA and opB.
- R4: Function 8 shifts opA left, function 9 shifts it right filling with zeros, and function 10 (hex A) shifts it right copying the sign bit. The shift amount is the low log2(WIDTH) bits of opB, and the upper bits of opB are ignored.
- R5: Function 11 (hex B) sign-extends opA[7:0] to WIDTH bits. Function 12 (hex C) sign-extends opA[15:0]. When WIDTH is 16, function 12 passes opA through unchanged.
- R6: Functions 13 to 15 drive the result to zero and set badFunc to 1. Every legal function clears badFunc.
- R7: When immMode is 1, only functions 2 through 10 are legal. Functions 0, 1, 11 and 12 then behave like R6: the result is zero and badFunc is 1.
- R8: isEqual is 1 exactly when opA equals opB, whatever the function code and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand, register value or immediate |
| funcCode | input | 4 | Operation select |
| immMode | input | 1 | Operation uses an immediate operand |
| result | output | WIDTH | Operation result |
| isEqual | output | 1 | opA equals opB |
| badFunc | output | 1 | Function code is illegal in this mode |

## Verification
Every output is purely combinational, so each result is due in the same cycle its inputs are applied, with no register on the path. The bench changes the inputs on the falling clock edge. It samples the outputs a short settle time later, well before the next rising edge, so each check sees only the vector just applied. A fixed table covers the wrap, signed-extreme, shift and decode corners. Random operands are then checked against an independent behavioural model, and a second 16-bit instance covers the halfword pass-through.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    FN_ADD = 4'h0, FN_SUB = 4'h1, FN_LTU = 4'h2, FN_LTS = 4'h3,
    FN_AND = 4'h4, FN_OR  = 4'h5, FN_XOR = 4'h6, FN_NOR = 4'h7,
    FN_SHL = 4'h8, FN_SHR = 4'h9, FN_SRA = 4'hA, FN_SXB = 4'hB,
    FN_SXH = 4'hC
  } aluFunc_e;

  // One-hot strobes from control to datapath (all zero when illegal)
  typedef struct packed {
    logic doAdd;
    logic doSub;
    logic doLtu;
    logic doLts;
    logic doAnd;
    logic doOr;
    logic doXor;
    logic doNor;
    logic doShl;
    logic doShr;
    logic doSra;
    logic doSxb;
    logic doSxh;
  } aluStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0]  funcCode,
  input  logic        immMode,
  output aluStrobe_t  strobes,
  output logic        badFunc
);

  logic legalReg;
  logic legalImm;

  always_comb begin
    strobes = '0;
    case (funcCode)
      FN_ADD: strobes.doAdd = 1'b1;
      FN_SUB: strobes.doSub = 1'b1;
      FN_LTU: strobes.doLtu = 1'b1;
      FN_LTS: strobes.doLts = 1'b1;
      FN_AND: strobes.doAnd = 1'b1;
      FN_OR:  strobes.doOr  = 1'b1;
      FN_XOR: strobes.doXor = 1'b1;
      FN_NOR: strobes.doNor = 1'b1;
      FN_SHL: strobes.doShl = 1'b1;
      FN_SHR: strobes.doShr = 1'b1;
      FN_SRA: strobes.doSra = 1'b1;
      FN_SXB: strobes.doSxb = 1'b1;
      FN_SXH: strobes.doSxh = 1'b1;
      default: strobes = '0;
    endcase
    legalReg = (funcCode <= FN_SXH);
    legalImm = (funcCode >= FN_LTU) && (funcCode <= FN_SRA);
    if (immMode ? !legalImm : !legalReg) strobes = '0;
    badFunc = (strobes == '0);
  end

  // R6: at most one operation selected; invalid means none
  always_comb begin
    a_r6_onehot_strobes: assert ($onehot0(strobes))
      else $error("strobes not one-hot");
  end

  // R7: immediate mode never selects add, subtract or sign extension
  always_comb begin
    a_r7_imm_restrict: assert (!immMode ||
        !(strobes.doAdd || strobes.doSub || strobes.doSxb || strobes.doSxh))
      else $error("illegal immediate operation selected");
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobe_t       strobes,
  output logic [WIDTH-1:0] result,
  output logic             isEqual
);

  localparam int SHW = $clog2(WIDTH);

  logic [WIDTH-1:0] sumVal;
  logic [WIDTH:0]   diffExt;
  logic [WIDTH-1:0] diffVal;
  logic             borrow;
  logic             ltsBit;
  logic [SHW-1:0]   shamt;
  logic [WIDTH-1:0] shlVal, shrVal, sraVal, sxbVal, sxhVal;

  assign sumVal  = opA + opB;
  assign diffExt = {1'b0, opA} + {1'b0, ~opB} + {{WIDTH{1'b0}}, 1'b1};
  assign diffVal = diffExt[WIDTH-1:0];
  assign borrow  = ~diffExt[WIDTH];
  // Signs differ: negative operand is smaller; otherwise the difference sign decides
  assign ltsBit  = (opA[WIDTH-1] ^ opB[WIDTH-1]) ? opA[WIDTH-1] : diffVal[WIDTH-1];
  assign shamt   = opB[SHW-1:0];
  assign shlVal  = opA << shamt;
  assign shrVal  = opA >> shamt;
  assign sraVal  = $unsigned($signed(opA) >>> shamt);
  assign sxbVal  = {{(WIDTH-8){opA[7]}}, opA[7:0]};

  generate
    if (WIDTH > 16) begin : g_sxhExt
      assign sxhVal = {{(WIDTH-16){opA[15]}}, opA[15:0]};
    end else begin : g_sxhPass
      assign sxhVal = opA;
    end
  endgenerate

  always_comb begin
    result = ({WIDTH{strobes.doAdd}} & sumVal)
           | ({WIDTH{strobes.doSub}} & diffVal)
           | ({WIDTH{strobes.doLtu}} & {{(WIDTH-1){1'b0}}, borrow})
           | ({WIDTH{strobes.doLts}} & {{(WIDTH-1){1'b0}}, ltsBit})
           | ({WIDTH{strobes.doAnd}} & (opA & opB))
           | ({WIDTH{strobes.doOr}}  & (opA | opB))
           | ({WIDTH{strobes.doXor}} & (opA ^ opB))
           | ({WIDTH{strobes.doNor}} & ~(opA | opB))
           | ({WIDTH{strobes.doShl}} & shlVal)
           | ({WIDTH{strobes.doShr}} & shrVal)
           | ({WIDTH{strobes.doSra}} & sraVal)
           | ({WIDTH{strobes.doSxb}} & sxbVal)
           | ({WIDTH{strobes.doSxh}} & sxhVal);
  end

  assign isEqual = (opA == opB);

  // R2: compare results are boolean
  always_comb begin
    a_r2_lt_boolean: assert (!(strobes.doLtu || strobes.doLts) || (result[WIDTH-1:1] == '0))
      else $error("compare result not 0/1");
  end

  // R6: no strobe means a zero result
  always_comb begin
    a_r6_invalid_zero: assert (strobes != '0 || result == '0)
      else $error("invalid function produced nonzero result");
  end

  // R8: equality agrees with the subtractor
  always_comb begin
    a_r8_eq_diff: assert (isEqual == (diffVal == '0))
      else $error("equality disagrees with difference");
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       funcCode,
  input  logic             immMode,
  output logic [WIDTH-1:0] result,
  output logic             isEqual,
  output logic             badFunc
);

  aluStrobe_t strobes;

  alu_ctrl u_ctrl (
    .funcCode (funcCode),
    .immMode  (immMode),
    .strobes  (strobes),
    .badFunc  (badFunc)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .isEqual (isEqual)
  );

endmodule

// File: tb/tb_int_alu.sv
module tb_int_alu;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  fn;
    logic        imm;
    logic [31:0] exp;
    logic        eq;
    logic        bad;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VEC [NVEC] = '{
    {32'h00000005, 32'h00000003, 4'h0, 1'b0, 32'h00000008, 1'b0, 1'b0}, // R1
    {32'hFFFFFFFF, 32'h00000001, 4'h0, 1'b0, 32'h00000000, 1'b0, 1'b0}, // R1 wrap
    {32'h00000000, 32'h00000001, 4'h1, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b0}, // R1 wrap
    {32'h00000001, 32'hFFFFFFFF, 4'h2, 1'b0, 32'h00000001, 1'b0, 1'b0}, // R2
    {32'h00000001, 32'hFFFFFFFF, 4'h3, 1'b0, 32'h00000000, 1'b0, 1'b0}, // R2
    {32'h80000000, 32'h7FFFFFFF, 4'h3, 1'b0, 32'h00000001, 1'b0, 1'b0}, // R2
    {32'h80000000, 32'h7FFFFFFF, 4'h2, 1'b0, 32'h00000000, 1'b0, 1'b0}, // R2
    {32'hF0F0F0F0, 32'hFF00FF00, 4'h4, 1'b0, 32'hF000F000, 1'b0, 1'b0}, // R3
    {32'hF0F0F0F0, 32'hFF00FF00, 4'h5, 1'b0, 32'hFFF0FFF0, 1'b0, 1'b0}, // R3
    {32'hF0F0F0F0, 32'hFF00FF00, 4'h6, 1'b0, 32'h0FF00FF0, 1'b0, 1'b0}, // R3
    {32'hF0F0F0F0, 32'hFF00FF00, 4'h7, 1'b0, 32'h000F000F, 1'b0, 1'b0}, // R3
    {32'h00000001, 32'h00000023, 4'h8, 1'b0, 32'h00000008, 1'b0, 1'b0}, // R4 upper b ignored
    {32'h80000000, 32'h0000003F, 4'h9, 1'b0, 32'h00000001, 1'b0, 1'b0}, // R4
    {32'h80000000, 32'h00000004, 4'hA, 1'b0, 32'hF8000000, 1'b0, 1'b0}, // R4
    {32'h00000080, 32'h00000000, 4'hB, 1'b0, 32'hFFFFFF80, 1'b0, 1'b0}, // R5
    {32'h12348000, 32'h00000000, 4'hC, 1'b0, 32'hFFFF8000, 1'b0, 1'b0}, // R5
    {32'h00000005, 32'h00000005, 4'hD, 1'b0, 32'h00000000, 1'b1, 1'b1}, // R6
    {32'h00000005, 32'h00000003, 4'h0, 1'b1, 32'h00000000, 1'b0, 1'b1}, // R7
    {32'h00000005, 32'h00000003, 4'h5, 1'b1, 32'h00000007, 1'b0, 1'b0}, // R7
    {32'h00000007, 32'h00000007, 4'hC, 1'b1, 32'h00000000, 1'b1, 1'b1}  // R7
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] opA, opB, result;
  logic [3:0]  funcCode;
  logic        immMode, isEqual, badFunc;
  logic [15:0] hA, hB, hResult;
  logic [3:0]  hFunc;
  logic        hEq, hBad;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int_alu #(.WIDTH(32)) dut (
    .opA(opA), .opB(opB), .funcCode(funcCode), .immMode(immMode),
    .result(result), .isEqual(isEqual), .badFunc(badFunc)
  );

  int_alu #(.WIDTH(16)) dut16 (
    .opA(hA), .opB(hB), .funcCode(hFunc), .immMode(1'b0),
    .result(hResult), .isEqual(hEq), .badFunc(hBad)
  );

  function automatic logic [32:0] refModel(logic [31:0] a, logic [31:0] b,
                                           logic [3:0] fn, logic imm);
    logic [31:0] r;
    logic ok;
    ok = imm ? (fn >= 4'd2 && fn <= 4'd10) : (fn <= 4'd12);
    case (fn)
      4'd0:  r = a + b;
      4'd1:  r = a - b;
      4'd2:  r = (a < b) ? 32'd1 : 32'd0;
      4'd3:  r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd4:  r = a & b;
      4'd5:  r = a | b;
      4'd6:  r = a ^ b;
      4'd7:  r = ~(a | b);
      4'd8:  r = a << b[4:0];
      4'd9:  r = a >> b[4:0];
      4'd10: r = $unsigned($signed(a) >>> b[4:0]);
      4'd11: r = {{24{a[7]}}, a[7:0]};
      4'd12: r = {{16{a[15]}}, a[15:0]};
      default: r = 32'd0;
    endcase
    if (!ok) r = 32'd0;
    return {!ok, r};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [31:0] b, logic [3:0] fn, logic imm);
    @(negedge clk);
    opA = a; opB = b; funcCode = fn; immMode = imm;
    #2;
  endtask

  task automatic apply16(logic [15:0] a, logic [15:0] b, logic [3:0] fn);
    @(negedge clk);
    hA = a; hB = b; hFunc = fn;
    #2;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [32:0] ref33;
    logic [31:0] ra, rb;
    logic [3:0]  rf;
    logic        ri;
    opA = '0; opB = '0; funcCode = '0; immMode = 1'b0;
    hA = '0; hB = '0; hFunc = '0;
    repeat (2) @(posedge clk);
    rstN = 1'b1;

    // Idle state: zero operands, add
    apply(32'd0, 32'd0, 4'h0, 1'b0);
    check("R1 idle result", result, 32'd0);
    check("R8 idle isEqual", {31'd0, isEqual}, 32'd1);
    check("R6 idle badFunc", {31'd0, badFunc}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i].a, VEC[i].b, VEC[i].fn, VEC[i].imm);
      check("R1-table result", result, VEC[i].exp);
      check("R8 table isEqual", {31'd0, isEqual}, {31'd0, VEC[i].eq});
      check("R6 table badFunc", {31'd0, badFunc}, {31'd0, VEC[i].bad});
    end

    // R2 / R4 signed extremes
    apply(32'h7FFFFFFF, 32'h80000000, 4'h3, 1'b0);
    check("R2 max<min signed", result, 32'd0);
    apply(32'h80000000, 32'h0000001F, 4'hA, 1'b1);
    check("R4 sra by 31 imm", result, 32'hFFFFFFFF);
    apply(32'h80000000, 32'h80000000, 4'h3, 1'b0);
    check("R2 equal operands", result, 32'd0);
    check("R8 equal min", {31'd0, isEqual}, 32'd1);
    apply(32'h00000001, 32'h00000000, 4'hF, 1'b0);
    check("R6 fn F", result, 32'd0);
    check("R6 fn F bad", {31'd0, badFunc}, 32'd1);

    // 16-bit instance
    apply16(16'h1280, 16'h0000, 4'hC);
    check("R5 w16 pass", {16'd0, hResult}, {16'd0, 16'h1280});
    apply16(16'h1280, 16'h0000, 4'hB);
    check("R5 w16 sxb", {16'd0, hResult}, {16'd0, 16'hFF80});
    apply16(16'h0001, 16'h0013, 4'h8);
    check("R4 w16 shamt", {16'd0, hResult}, {16'd0, 16'h0008});
    apply16(16'h8000, 16'h000F, 4'hA);
    check("R4 w16 sra", {16'd0, hResult}, {16'd0, 16'hFFFF});
    check("R6 w16 bad", {31'd0, hBad}, 32'd0);
    check("R8 w16 eq", {31'd0, hEq}, 32'd0);

    // Random operands against the model
    for (int k = 0; k < 400; k++) begin
      ra = $urandom; rb = $urandom;
      if (k % 8 == 0) ra = 32'h80000000;
      if (k % 8 == 1) rb = 32'h7FFFFFFF;
      if (k % 8 == 2) rb = ra;
      rf = 4'($urandom_range(0, 15));
      ri = 1'($urandom_range(0, 1));
      ref33 = refModel(ra, rb, rf, ri);
      apply(ra, rb, rf, ri);
      check("R1-R7 random result", result, ref33[31:0]);
      check("R7 random badFunc", {31'd0, badFunc}, {31'd0, ref33[32]});
      check("R8 random isEqual", {31'd0, isEqual}, {31'd0, ra == rb});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule